// File: doc/BRIEF.md
# Port Collision Partition Controller

This block runs once per switch port and decides when the port is cut off from normal collision handling and when it rejoins. It watches the collision indication from the MAC, the start and end of each transmit attempt, a bit-time tick and a flag that marks a start as a retry of the same packet. Two faults put the port into the partitioned state. The first is a run of collided attempts on one packet. The second is one collision that lasts too many bit times. Partitioning is only possible when the active-low enable strap reads low while reset is held.

While partitioned, the port keeps sending. Back-off is suppressed and the transmit path is told to ignore collisions, so queued packets drain and do not fill the buffers. The port returns to normal at the end of any transmission whose opening bits carried no collision. The partitioned state is also driven out as an LED status bit.

Top module: `port_partition_ctl`

## Requirements
- R1: The active-low strap `part_strap_n` is sampled on every clock edge while `rst_n` is low. If it was high, `partitioned` never asserts, whatever the collision activity.
- R2: A run of RETRY_LIMIT (default 64) consecutive collided attempts of one packet sets `partitioned`. It is high in the cycle after the `tx_end` of the last attempt in that run.
- R3: A `tx_start` with `tx_retry` low marks a new packet and clears the count of consecutive collided attempts.
- R4: An attempt that ends with no collision seen clears the count of consecutive collided attempts.
- R5: A collision that stays asserted for more than LONG_COL_BITS (default 512) bit ticks sets `partitioned`. A collision held for exactly LONG_COL_BITS ticks or fewer does not. Deasserting `col` restarts the duration count.
- R6: A partitioned port leaves the partitioned state at a `tx_end` when no collision was seen during the first CLEAN_BITS (default 512) bit ticks of that attempt. A collision seen after that window does not prevent the exit.
- R7: A partitioned port stays partitioned after an attempt that saw a collision within its first CLEAN_BITS ticks.
- R8: `backoff_off`, `col_ignore` and `led_part` all follow `partitioned`, and all four outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| part_strap_n | input | 1 | Active-low partition enable strap |
| col | input | 1 | Collision indication from the MAC |
| tx_start | input | 1 | One-cycle pulse at the start of a transmit attempt |
| tx_retry | input | 1 | Qualifies `tx_start`: high for a retry of the same packet |
| tx_end | input | 1 | One-cycle pulse at the end of a transmit attempt |
| bit_tick | input | 1 | One pulse per bit time on the wire |
| partitioned | output | 1 | Port is in the partitioned state |
| backoff_off | output | 1 | Suppress the back-off algorithm |
| col_ignore | output | 1 | Transmit path ignores collisions |
| led_part | output | 1 | Partition status for the LED output |

## Verification
The assertions assume that `tx_start` and `tx_end` are single-cycle pulses that alternate and never coincide. They also assume that a change of `partitioned` can only follow an end-of-attempt event or a collision tick. The bench keeps to these assumptions by driving every attempt through one task. That task issues the start pulse, then a chosen number of ticks, then the end pulse, and drops `col` before the end cycle. Long collisions are driven only while no attempt is open, so the duration rule and the attempt rules are exercised apart from each other.

// File: rtl/port_partition_ctl.sv
module port_partition_ctl #(
  parameter int RETRY_LIMIT   = 64,
  parameter int LONG_COL_BITS = 512,
  parameter int CLEAN_BITS    = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic part_strap_n,
  input  logic col,
  input  logic tx_start,
  input  logic tx_retry,
  input  logic tx_end,
  input  logic bit_tick,
  output logic partitioned,
  output logic backoff_off,
  output logic col_ignore,
  output logic led_part
);
  localparam int RW = $clog2(RETRY_LIMIT + 1);
  localparam int DW = $clog2(LONG_COL_BITS + 2);
  localparam int PW = $clog2(CLEAN_BITS + 1);

  logic          part_en;
  logic          part_q;
  logic          tx_act;
  logic          att_col;
  logic          early_col;
  logic [RW-1:0] retry_cnt;
  logic [DW-1:0] dur_cnt;
  logic [PW-1:0] pos_cnt;

  wire early_now   = tx_act && col && (pos_cnt < PW'(CLEAN_BITS));
  wire att_col_now = att_col || (tx_act && col);
  wire end_evt     = tx_end && tx_act;
  wire retry_hit   = end_evt && att_col_now && (retry_cnt == RW'(RETRY_LIMIT - 1));
  wire long_hit    = col && bit_tick && (dur_cnt == DW'(LONG_COL_BITS));
  wire clean_end   = end_evt && !(early_col || early_now);
  wire enter       = part_en && !part_q && (retry_hit || long_hit);
  wire leave       = part_q && clean_end;

  always_ff @(posedge clk)
    if (!rst_n) part_en <= ~part_strap_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q    <= 1'b0;
      tx_act    <= 1'b0;
      att_col   <= 1'b0;
      early_col <= 1'b0;
      retry_cnt <= '0;
      dur_cnt   <= '0;
      pos_cnt   <= '0;
    end else begin
      if (enter)      part_q <= 1'b1;
      else if (leave) part_q <= 1'b0;

      if (tx_start)    tx_act <= 1'b1;
      else if (tx_end) tx_act <= 1'b0;

      if (tx_start) begin
        pos_cnt   <= '0;
        att_col   <= 1'b0;
        early_col <= 1'b0;
      end else begin
        if (tx_act && bit_tick && pos_cnt != PW'(CLEAN_BITS)) pos_cnt <= pos_cnt + 1'b1;
        if (tx_act && col) att_col <= 1'b1;
        if (early_now) early_col <= 1'b1;
      end

      if (tx_start && !tx_retry) retry_cnt <= '0;
      else if (end_evt) begin
        if (!att_col_now) retry_cnt <= '0;
        else if (retry_cnt != RW'(RETRY_LIMIT)) retry_cnt <= retry_cnt + 1'b1;
      end

      if (!col) dur_cnt <= '0;
      else if (bit_tick && dur_cnt != DW'(LONG_COL_BITS + 1)) dur_cnt <= dur_cnt + 1'b1;
    end
  end

  assign partitioned = part_q;
  assign backoff_off = part_q;
  assign col_ignore  = part_q;
  assign led_part    = part_q;
endmodule

// File: rtl/port_partition_chk.sv
module port_partition_chk #(
  parameter int LONG_COL_BITS = 512,
  parameter int CLEAN_BITS    = 512
) (
  input logic clk,
  input logic rst_n,
  input logic col,
  input logic tx_end,
  input logic bit_tick,
  input logic partitioned,
  input logic part_en,
  input logic [$clog2(LONG_COL_BITS+2)-1:0] dur_cnt,
  input logic [$clog2(CLEAN_BITS+1)-1:0] pos_cnt
);
  // R1
  strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !part_en |-> !partitioned);

  // R1
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(partitioned) |-> $past(part_en));

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(partitioned) |-> $past(tx_end || (col && bit_tick)));

  // R6
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(partitioned) |-> $past(tx_end));

  // R5
  long_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (part_en && col && bit_tick && dur_cnt == ($clog2(LONG_COL_BITS+2))'(LONG_COL_BITS)) |=> partitioned);

  // R5
  dur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dur_cnt <= ($clog2(LONG_COL_BITS+2))'(LONG_COL_BITS + 1));

  // R6
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_cnt <= ($clog2(CLEAN_BITS+1))'(CLEAN_BITS));
endmodule

bind port_partition_ctl port_partition_chk #(
  .LONG_COL_BITS(LONG_COL_BITS),
  .CLEAN_BITS(CLEAN_BITS)
) u_part_chk (
  .clk(clk), .rst_n(rst_n), .col(col), .tx_end(tx_end), .bit_tick(bit_tick),
  .partitioned(partitioned), .part_en(part_en), .dur_cnt(dur_cnt), .pos_cnt(pos_cnt)
);

// File: tb/test_port_partition_ctl.sv
module test_port_partition_ctl;
  localparam int PERIOD = 10;
  localparam int RL = 5;
  localparam int LC = 9;
  localparam int CB = 10;

  logic clk = 0, rst_n = 0, strap_n = 0;
  logic col = 0, tx_start = 0, tx_retry = 0, tx_end = 0, bit_tick = 0;
  logic partitioned, backoff_off, col_ignore, led_part;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  port_partition_ctl #(.RETRY_LIMIT(RL), .LONG_COL_BITS(LC), .CLEAN_BITS(CB)) i_port_partition_ctl (
    .clk(clk), .rst_n(rst_n), .part_strap_n(strap_n), .col(col), .tx_start(tx_start),
    .tx_retry(tx_retry), .tx_end(tx_end), .bit_tick(bit_tick), .partitioned(partitioned),
    .backoff_off(backoff_off), .col_ignore(col_ignore), .led_part(led_part));

  task automatic expect_part(input bit exp, input string req);
    checks++;
    if ({partitioned, backoff_off, col_ignore, led_part} !== {4{exp}}) begin
      errors++;
      $display("FAIL %s: outputs=%b expected=%b", req,
               {partitioned, backoff_off, col_ignore, led_part}, {4{exp}});
    end
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst_n = 0; strap_n = strap;
    col = 0; tx_start = 0; tx_end = 0; bit_tick = 0; tx_retry = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // cp < 0: no collision; else collision on tick index cp
  task automatic attempt(input bit retry, input int cp, input int ticks);
    tx_start = 1; tx_retry = retry;
    @(negedge clk);
    tx_start = 0; tx_retry = 0;
    for (int i = 0; i < ticks; i++) begin
      bit_tick = 1; col = (i == cp);
      @(negedge clk);
    end
    bit_tick = 0; col = 0;
    tx_end = 1;
    @(negedge clk);
    tx_end = 0;
  endtask

  task automatic long_col(input int d);
    col = 1;
    for (int i = 0; i < d; i++) begin
      bit_tick = 1;
      @(negedge clk);
    end
    bit_tick = 0; col = 0;
    @(negedge clk);
  endtask

  initial begin
    do_reset(0);
    expect_part(0, "R8 reset state");

    // R2: sweep run length
    for (int n = 0; n <= RL + 1; n++) begin
      do_reset(0);
      for (int k = 1; k <= n; k++) attempt(k != 1, 0, 3);
      expect_part(n >= RL, "R2 consecutive collided attempts");
    end

    // R3: new packet restarts the run
    do_reset(0);
    for (int k = 0; k < RL - 1; k++) attempt(k != 0, 1, 3);
    for (int k = 0; k < RL - 1; k++) attempt(k != 0, 1, 3);
    expect_part(0, "R3 new packet clears count");
    attempt(1, 1, 3);
    expect_part(1, "R3 run completes on new packet");

    // R4: clean attempt clears the run
    do_reset(0);
    for (int k = 0; k < RL - 1; k++) attempt(k != 0, 0, 3);
    attempt(1, -1, 3);
    for (int k = 0; k < RL - 1; k++) attempt(1, 0, 3);
    expect_part(0, "R4 clean attempt clears count");
    attempt(1, 0, 3);
    expect_part(1, "R4 full run after clear");

    // R5: long collision sweep
    for (int d = LC - 2; d <= LC + 2; d++) begin
      do_reset(0);
      long_col(d);
      expect_part(d > LC, "R5 long collision");
    end
    do_reset(0);
    long_col(LC); long_col(LC);
    expect_part(0, "R5 release restarts duration");

    // R6/R7: exit sweep over collision position
    for (int p = -1; p <= CB + 2; p++) begin
      do_reset(0);
      long_col(LC + 1);
      expect_part(1, "R6 setup partition");
      attempt(1, p, CB + 4);
      if (p >= 0 && p < CB) expect_part(1, "R7 early collision keeps partition");
      else expect_part(0, "R6 exit after clean opening bits");
    end

    // R1: strap disabled
    do_reset(1);
    for (int k = 0; k < RL + 2; k++) attempt(k != 0, 0, 3);
    expect_part(0, "R1 strap off, retries");
    long_col(LC + 4);
    expect_part(0, "R1 strap off, long collision");
    do_reset(0);
    long_col(LC + 1);
    expect_part(1, "R1 strap on re-enables");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule